// File: doc/BRIEF.md
# Block Floating-Point Stage Scaler

This block sits between the butterfly arithmetic of a multi-stage FFT and the storage that holds the data for the next stage. Each butterfly result arrives 18 bits wide but is stored as 16 bits. The scaler inspects the three most significant bits of every valid result to judge how much that result grew. It keeps the largest growth seen during the current stage.

When the stage-end strobe arrives, the worst growth of the stage becomes the right-shift amount for the next stage: 0, 1 or 2 bits. From then on, every result is shifted arithmetically by that amount and truncated to 16 bits. Each stage decision is also added to a running exponent. The exponent tells the consumer how many powers of two the stored words have been divided by since the frame began. A frame-start strobe begins a new transform.

Top module: `bfp_scaler`

## Requirements
- R1: The growth class of a result comes from its top three bits (bits 17..15 at the default width). 000 and 111 give class 0, 001 and 110 give class 1, and 010, 011, 100 and 101 give class 2. A stage whose worst result has class c sets shift_o to c.
- R2: The stage decision is the largest class among the valid results of the stage, including a valid result presented in the same cycle as the stage-end strobe. Data presented with in_valid_i low does not affect the decision.
- R3: A new shift appears on shift_o one cycle after the stage-end strobe. It applies to every result presented from that cycle onward. A result presented in the cycle of the strobe still uses the old shift.
- R4: out_valid_o equals in_valid_i delayed by one cycle. When out_valid_o is high, out_data_o holds the 16 least significant bits of the input after an arithmetic right shift by the shift in force when the input was presented.
- R5: At each stage-end strobe, exponent_o increases by that stage's decision (0, 1 or 2) and is visible one cycle later. It does not change in any other cycle except a frame start.
- R6: A frame-start strobe clears exponent_o, shift_o and the running maximum in the next cycle. It takes priority over a stage-end strobe in the same cycle.
- R7: While rst is high, out_valid_o, out_data_o, shift_o and exponent_o are all zero on the cycle after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Start of a new transform |
| stage_end_i | input | 1 | Last cycle of the current stage |
| in_valid_i | input | 1 | in_data_i holds a result |
| in_data_i | input | IN_W (18) | Two's-complement butterfly result |
| out_valid_o | output | 1 | out_data_o holds a scaled word |
| out_data_o | output | OUT_W (16) | Scaled result |
| shift_o | output | 2 | Shift in force for the current stage |
| exponent_o | output | EXP_W (5) | Total shift accumulated over the frame |

## Verification
The bench uses the default parameters: IN_W=18, OUT_W=16 and EXP_W=5. With these values all eight top-bit patterns can be reached with small and large signed values. A 9-stage frame that peaks at class 2 in several stages totals an exponent of 9 without wrapping. Five bits hold up to 31, so the accumulation stays in range even when all nine stages pick a shift of 2.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef logic [1:0] grow_t;
  localparam grow_t GROW_NONE = 2'd0;
  localparam grow_t GROW_ONE  = 2'd1;
  localparam grow_t GROW_TWO  = 2'd2;
endpackage

// File: rtl/bfp_classify.sv
module bfp_classify
  import bfp_pkg::*;
#(
  parameter int IN_W = 18
) (
  input  logic [IN_W-1:0] data_i,
  output grow_t           grow_o
);
  logic [2:0] head;
  assign head = data_i[IN_W-1 -: 3];

  always_comb begin
    unique case (head)
      3'b000, 3'b111: grow_o = GROW_NONE;
      3'b001, 3'b110: grow_o = GROW_ONE;
      default:        grow_o = GROW_TWO;
    endcase
  end
endmodule

// File: rtl/bfp_tracker.sv
module bfp_tracker
  import bfp_pkg::*;
#(
  parameter int EXP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start_i,
  input  logic             stage_end_i,
  input  logic             valid_i,
  input  grow_t            grow_i,
  output grow_t            shift_o,
  output logic [EXP_W-1:0] exponent_o
);
  grow_t run_max, cand, decision;

  assign cand     = valid_i ? grow_i : GROW_NONE;
  assign decision = (cand > run_max) ? cand : run_max;

  always_ff @(posedge clk) begin
    if (rst || frame_start_i) begin
      run_max    <= GROW_NONE;
      shift_o    <= GROW_NONE;
      exponent_o <= '0;
    end else if (stage_end_i) begin
      run_max    <= GROW_NONE;
      shift_o    <= decision;
      exponent_o <= exponent_o + EXP_W'(decision);
    end else begin
      run_max <= decision;
    end
  end

  AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (rst)
    shift_o != 2'd3); // R1
  AST_EXP_ACCUM: assert property (@(posedge clk) disable iff (rst)
    (stage_end_i && !frame_start_i) |=> exponent_o == $past(exponent_o) + EXP_W'(shift_o)); // R5
  AST_EXP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!stage_end_i && !frame_start_i) |=> ($stable(exponent_o) && $stable(shift_o))); // R5
  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (rst)
    frame_start_i |=> (exponent_o == '0 && shift_o == GROW_NONE)); // R6
  AST_MAX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!stage_end_i && !frame_start_i) |=> run_max >= $past(run_max)); // R2
endmodule

// File: rtl/bfp_shifter.sv
module bfp_shifter
  import bfp_pkg::*;
#(
  parameter int IN_W  = 18,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  input  grow_t            shift_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o
);
  logic signed [IN_W-1:0] sdata, shifted;
  assign sdata   = data_i;
  assign shifted = sdata >>> shift_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= shifted[OUT_W-1:0];
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(data_o)); // R4
endmodule

// File: rtl/bfp_scaler.sv
module bfp_scaler
  import bfp_pkg::*;
#(
  parameter int IN_W  = 18,
  parameter int OUT_W = 16,
  parameter int EXP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start_i,
  input  logic             stage_end_i,
  input  logic             in_valid_i,
  input  logic [IN_W-1:0]  in_data_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_data_o,
  output logic [1:0]       shift_o,
  output logic [EXP_W-1:0] exponent_o
);
  grow_t grow, cur_shift;

  bfp_classify #(.IN_W(IN_W)) u_cls (
    .data_i (in_data_i),
    .grow_o (grow)
  );

  bfp_tracker #(.EXP_W(EXP_W)) u_trk (
    .clk           (clk),
    .rst           (rst),
    .frame_start_i (frame_start_i),
    .stage_end_i   (stage_end_i),
    .valid_i       (in_valid_i),
    .grow_i        (grow),
    .shift_o       (cur_shift),
    .exponent_o    (exponent_o)
  );

  bfp_shifter #(.IN_W(IN_W), .OUT_W(OUT_W)) u_shf (
    .clk     (clk),
    .rst     (rst),
    .valid_i (in_valid_i),
    .data_i  (in_data_i),
    .shift_i (cur_shift),
    .valid_o (out_valid_o),
    .data_o  (out_data_o)
  );

  assign shift_o = cur_shift;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid_o && exponent_o == '0 && shift_o == 2'd0)); // R7
endmodule

// File: tb/tb_bfp_scaler.sv
module tb_bfp_scaler;
  localparam int IN_W = 18, OUT_W = 16, EXP_W = 5;

  logic clk = 0, rst = 1, fs = 0, se = 0, iv = 0;
  logic [IN_W-1:0] idata = '0;
  logic out_valid;
  logic [OUT_W-1:0] out_data;
  logic [1:0] shift;
  logic [EXP_W-1:0] expo;

  int checks = 0, fails = 0;
  bit done = 0;

  bfp_scaler #(.IN_W(IN_W), .OUT_W(OUT_W), .EXP_W(EXP_W)) dut (
    .clk(clk), .rst(rst), .frame_start_i(fs), .stage_end_i(se),
    .in_valid_i(iv), .in_data_i(idata), .out_valid_o(out_valid),
    .out_data_o(out_data), .shift_o(shift), .exponent_o(expo));

  always #2.5 clk = ~clk;

  // reference model: growth by numeric range of the signed value
  int m_exp = 0, m_sh = 0, m_max = 0, m_ov = 0, m_od = 0;

  function automatic int grow_of(logic [IN_W-1:0] d);
    int v;
    v = int'($signed(d));
    if (v >= -32768 && v <= 32767) return 0;
    if (v >= -65536 && v <= 65535) return 1;
    return 2;
  endfunction

  always @(posedge clk) begin
    int c, dec;
    if (rst) begin
      m_exp = 0; m_sh = 0; m_max = 0; m_ov = 0; m_od = 0;
    end else begin
      c = iv ? grow_of(idata) : 0;
      dec = (c > m_max) ? c : m_max;
      m_ov = iv;
      if (iv) m_od = (int'($signed(idata)) >>> m_sh) & 32'hFFFF;
      if (fs) begin m_exp = 0; m_sh = 0; m_max = 0; end
      else if (se) begin m_sh = dec; m_exp = (m_exp + dec) % 32; m_max = 0; end
      else m_max = dec;
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (!done) begin
      check(int'(expo) == m_exp, "R5 exponent", int'(expo), m_exp);
      check(int'(shift) == m_sh, "R2 shift", int'(shift), m_sh);
      check(int'(out_valid) == m_ov, "R4 valid", int'(out_valid), m_ov);
      if (m_ov != 0)
        check(int'(out_data) == m_od, "R3 R4 data", int'(out_data), m_od);
    end
  end

  task automatic step(bit v, int d, bit s_end, bit f_start);
    @(negedge clk);
    iv = v; idata = IN_W'(d); se = s_end; fs = f_start;
  endtask

  task automatic idle();
    step(0, 0, 0, 0);
  endtask

  task automatic look(int exp_shift, int exp_expo, string req);
    @(posedge clk); #2;
    check(int'(shift) == exp_shift, req, int'(shift), exp_shift);
    check(int'(expo) == exp_expo, req, int'(expo), exp_expo);
  endtask

  function automatic int val_for(int g, bit neg);
    int v;
    v = (g == 0) ? 1000 : (g == 1) ? 40000 : 100000;
    return neg ? -v : v;
  endfunction

  int peaks[9] = '{0, 1, 2, 1, 0, 2, 2, 1, 0};
  int pat_class[8] = '{0, 1, 2, 2, 2, 2, 1, 0};

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 0 && out_data == 0 && shift == 0 && expo == 0, "R7 reset", int'(expo), 0);
    @(negedge clk); rst = 0;

    // R1: all eight top-bit patterns
    for (int p = 0; p < 8; p++) begin
      step(0, 0, 0, 1);
      step(1, (p << 15) | 16'h0123, 1, 0);
      look(pat_class[p], pat_class[p], "R1 pattern class");
    end

    // R2: invalid large data ignored; same-cycle result included
    step(0, 0, 0, 1);
    step(0, 100000, 0, 0);
    step(1, 5, 1, 0);
    look(0, 0, "R2 invalid ignored");
    step(1, 3, 0, 0);
    step(1, -40000, 1, 0);
    look(1, 1, "R2 last-cycle result counted");

    // R3: result on strobe cycle uses old shift, next uses new
    step(1, 100000, 1, 0);
    step(1, 100000, 0, 0);
    look(2, 3, "R3 shift switch");
    step(1, -3, 0, 0);
    idle();

    // R6: frame start beats stage end
    step(1, 100000, 0, 0);
    step(0, 0, 1, 1);
    look(0, 0, "R6 priority clear");
    step(0, 0, 1, 0);
    look(0, 0, "R6 running max cleared");

    // R5: nine-stage frame
    begin
      int total = 0;
      step(0, 0, 0, 1);
      for (int s = 0; s < 9; s++) begin
        for (int w = 0; w < 8; w++)
          step(1, (w == 3) ? val_for(peaks[s], s[0]) : val_for(0, w[0]) + w * 7, w == 7, 0);
        total += peaks[s];
        idle();
      end
      @(posedge clk); #2;
      check(int'(expo) == total && total == 9, "R5 nine-stage exponent", int'(expo), 9);
    end

    // R7: reset mid-run
    step(1, 100000, 1, 0);
    @(negedge clk); rst = 1; iv = 0; se = 0;
    @(posedge clk); #2;
    check(out_valid == 0 && shift == 0 && expo == 0, "R7 reset clears", int'(expo), 0);
    @(negedge clk); rst = 0;
    repeat (3) idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule